// File: doc/BRIEF.md
# Frame-Sync Alarm Interrupt Bank

This block sits next to a T1 frame-synchronization engine and turns what that engine reports into latched interrupt indications. Two inputs are levels: an in-frame flag and a multiframe-sync flag (SF or ESF). Each level input is registered into a status bit. Either edge of a status bit latches an indication for that source.

Five further inputs are single-cycle event pulses:

- a frame-alignment position that moved,
- a single-bit alignment-pattern error,
- an alignment pattern with two or more wrong bits,
- an SF-format alignment error,
- an ESF CRC-6 mismatch.

Each pulse sets its indication bit directly. Indications stay set until software reads the indication register. A per-source enable mask selects which indications drive the single active-high interrupt output.

Software reaches the block through a small register port. A request is one cycle wide: `req_valid` is high, `req_write` selects the direction, and `req_addr` selects the register. Read data is combinational in the cycle of the request. Register map:

| Address | Contents | Access |
|---|---|---|
| 0 | Status: bit 0 in-frame, bit 1 multiframe sync | read-only |
| 1 | Indications, bits 6:0 (see R3 and R5) | read-only, cleared by a read |
| 2 | Enables, bits 6:0, same layout as address 1 | read/write |
| 3 | Unused, reads 0 | — |

Top module: `frm_irq_bank`

## Requirements
- R1: After reset, the status, indication and enable registers all read 0, and `irq_o` is 0.
- R2: The status register (address 0) shows `lvl_i` as it was at the previous rising clock edge: bit 0 is in-frame and bit 1 is multiframe sync. Bits 7:2 read 0.
- R3: A rising edge on a registered level input sets its indication bit. In-frame sets bit 0 and multiframe sync sets bit 1 of address 1. The bit is visible from the cycle after the edge that changes the status.
- R4: A falling edge on a registered level input sets the same indication bit as a rising edge does.
- R5: A pulse on `evt_i[k]` sets indication bit k+2 on the next clock edge. The bits are:
  - bit 2: alignment position change
  - bit 3: single-bit pattern error
  - bit 4: multi-bit pattern error
  - bit 5: SF alignment error
  - bit 6: CRC-6 mismatch
- R6: A read of address 1 returns the current indications in bits 6:0, with bit 7 at 0. The read clears every indication bit at the next clock edge.
- R7: If a source sets an indication in the same cycle as a read of address 1, that bit is set after the clock edge. The event is not lost.
- R8: The enable register at address 2 holds bits 6:0 of the write data. Reads return these bits, and bit 7 reads 0.
- R9: `irq_o` equals the OR over all sources of indication AND enable, as those registers stood after the last clock edge.
- R10: Writes to addresses 0, 1 and 3 change no register.
- R11: With no read of address 1, an indication bit that is set stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_i | input | 2 | Level sources: bit 0 in-frame, bit 1 multiframe sync |
| evt_i | input | 5 | Event pulses: position change, 1-bit error, multi-bit error, SF error, CRC-6 mismatch |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, combinational, 0 when no read |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
On every cycle, the assertions check four things:
- The status register tracks the level inputs one cycle late.
- Every source that fires lands in its indication bit, including when a clearing read happens in the same cycle.
- Indications never drop without a read, and a read with no new event empties them.
- The interrupt output always matches the masked OR.

Some behaviours only the bench scenarios can show: that the two edge directions are both seen, that each pulse maps to its own bit position, that writes to read-only addresses leave state untouched, and the exact values seen through the read port. The bench shows these with a reference model fed by random stimulus and by directed sequences.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
    localparam int unsigned LVL_W  = 2;
    localparam int unsigned EVT_W  = 5;
    localparam int unsigned SRC_W  = LVL_W + EVT_W;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_IND    = 2'd1,
        REG_EN     = 2'd2,
        REG_RSVD   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/frm_irq_lvl_edge.sv
module frm_irq_lvl_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] chg_o
);
    typedef struct packed {
        logic [N-1:0] status;
    } lvl_state_t;

    lvl_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.status = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // one comparator per source: the input differs from its registered copy
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign chg_o[g] = lvl_i[g] ^ s_q.status[g];
    end

    assign status_o = s_q.status;
endmodule

// File: rtl/frm_irq_ind_latch.sv
module frm_irq_ind_latch #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] ind_o
);
    typedef struct packed {
        logic [N-1:0] ind;
    } ind_state_t;

    ind_state_t s_d, s_q;

    // set wins over clear, per bit, so a same-cycle event survives a read
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb begin
            s_d.ind[g] = set_i[g] | (s_q.ind[g] & ~clr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ind_o = s_q.ind;
endmodule

// File: rtl/frm_irq_regs.sv
module frm_irq_regs
    import frm_irq_pkg::*;
#(
    parameter int unsigned N_LVL = LVL_W,
    parameter int unsigned N_SRC = SRC_W,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [N_LVL-1:0] status_i,
    input  logic [N_SRC-1:0] ind_i,
    output logic [DW-1:0]    rdata_o,
    output logic             ind_clr_o,
    output logic [N_SRC-1:0] en_o
);
    localparam logic [AW-1:0] A_STATUS = AW'(REG_STATUS);
    localparam logic [AW-1:0] A_IND    = AW'(REG_IND);
    localparam logic [AW-1:0] A_EN     = AW'(REG_EN);

    typedef struct packed {
        logic [N_SRC-1:0] en;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic rd, wr;

    always_comb begin
        rd = req_valid & ~req_write;
        wr = req_valid &  req_write;

        s_d = s_q;
        if (wr && req_addr == A_EN) s_d.en = req_wdata[N_SRC-1:0];

        ind_clr_o = rd && (req_addr == A_IND);

        rdata_o = '0;
        if (rd) begin
            unique case (req_addr)
                A_STATUS: rdata_o[N_LVL-1:0] = status_i;
                A_IND:    rdata_o[N_SRC-1:0] = ind_i;
                A_EN:     rdata_o[N_SRC-1:0] = s_q.en;
                default:  rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o = s_q.en;
endmodule

// File: rtl/frm_irq_bank.sv
module frm_irq_bank
    import frm_irq_pkg::*;
#(
    parameter int unsigned N_LVL = LVL_W,
    parameter int unsigned N_EVT = EVT_W,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] lvl_i,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    rsp_rdata,
    output logic             irq_o
);
    localparam int unsigned N_SRC = N_LVL + N_EVT;

    typedef struct packed {
        logic irq;
    } top_state_t;

    logic [N_LVL-1:0] status_w;
    logic [N_LVL-1:0] chg_w;
    logic [N_SRC-1:0] set_w;
    logic [N_SRC-1:0] ind_w;
    logic [N_SRC-1:0] en_w;
    logic             clr_w;
    top_state_t       s_d, s_q;

    frm_irq_lvl_edge #(.N(N_LVL)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl_i),
        .status_o (status_w),
        .chg_o    (chg_w)
    );

    // level sources occupy the low indication bits, pulses follow
    assign set_w = {evt_i, chg_w};

    frm_irq_ind_latch #(.N(N_SRC)) u_ind (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_w),
        .clr_i (clr_w),
        .ind_o (ind_w)
    );

    frm_irq_regs #(
        .N_LVL (N_LVL),
        .N_SRC (N_SRC),
        .AW    (AW),
        .DW    (DW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .status_i  (status_w),
        .ind_i     (ind_w),
        .rdata_o   (rsp_rdata),
        .ind_clr_o (clr_w),
        .en_o      (en_w)
    );

    // the interrupt is a register fed by next-state values, so it lines up
    // with the indication and enable registers without a combinational path
    logic [N_SRC-1:0] ind_nx, en_nx;
    always_comb begin
        ind_nx = set_w | (ind_w & {N_SRC{~clr_w}});
        en_nx  = (req_valid && req_write && req_addr == AW'(REG_EN))
                 ? req_wdata[N_SRC-1:0] : en_w;
        s_d     = s_q;
        s_d.irq = |(ind_nx & en_nx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o = s_q.irq;
endmodule

// File: rtl/frm_irq_bank_chk.sv
module frm_irq_bank_chk #(
    parameter int unsigned N_LVL = 2,
    parameter int unsigned N_SRC = 7,
    parameter int unsigned AW    = 2,
    parameter int unsigned DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_LVL-1:0] lvl_i,
    input logic [N_LVL-1:0] status,
    input logic [N_SRC-1:0] set,
    input logic [N_SRC-1:0] ind,
    input logic [N_SRC-1:0] en,
    input logic             clr,
    input logic             irq,
    input logic             req_valid,
    input logic             req_write,
    input logic [AW-1:0]    req_addr,
    input logic [DW-1:0]    rdata
);
    assert_status_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status == $past(lvl_i));

    assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((ind & $past(set)) == $past(set)));

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((ind & $past(ind)) == $past(ind)));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> ind == '0);

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(ind & en));

    assert_en_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == AW'(2)) |-> rdata[DW-1:N_SRC] == '0);
endmodule

bind frm_irq_bank frm_irq_bank_chk #(
    .N_LVL (N_LVL),
    .N_SRC (N_LVL + N_EVT),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (lvl_i),
    .status    (status_w),
    .set       (set_w),
    .ind       (ind_w),
    .en        (en_w),
    .clr       (clr_w),
    .irq       (irq_o),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rdata     (rsp_rdata)
);

// File: tb/sim_frm_irq_bank.sv
module sim_frm_irq_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lvl_i = '0;
    logic [4:0] evt_i = '0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rsp_rdata;
    logic       irq_o;

    int checks = 0, failures = 0;
    logic [1:0] m_status = '0;
    logic [6:0] m_ind = '0, m_en = '0;
    logic       m_irq = 1'b0;

    always #4 clk = ~clk;

    frm_irq_bank u0 (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .evt_i(evt_i),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {6'b0, m_status};
            2'd1:    return {1'b0, m_ind};
            2'd2:    return {1'b0, m_en};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock cycle: check irq, drive inputs, check read data, update model
    task automatic cyc(input logic [1:0] lvl, input logic [4:0] evt, input logic v,
                       input logic w, input logic [1:0] a, input logic [7:0] wd,
                       input string tag);
        @(negedge clk);
        chk("R9 irq", {7'b0, irq_o}, {7'b0, m_irq});
        lvl_i = lvl; evt_i = evt; req_valid = v; req_write = w;
        req_addr = a; req_wdata = wd;
        #1;
        if (v && !w) chk(tag, rsp_rdata, exp_rd(a));
        m_ind = {evt, lvl ^ m_status} | (m_ind & ((v && !w && a == 2'd1) ? 7'h00 : 7'h7f));
        m_status = lvl;
        if (v && w && a == 2'd2) m_en = wd[6:0];
        m_irq = |(m_ind & m_en);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [1:0] lv;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        cyc(2'b00, 5'h0, 1, 0, 2'd0, 8'h0, "R1 status");
        cyc(2'b00, 5'h0, 1, 0, 2'd1, 8'h0, "R1 ind");
        cyc(2'b00, 5'h0, 1, 0, 2'd2, 8'h0, "R1 en");
        // R2/R3 rising edge of in-frame, then multiframe
        cyc(2'b01, 5'h0, 0, 0, 2'd0, 8'h0, "");
        cyc(2'b01, 5'h0, 1, 0, 2'd0, 8'h0, "R2 status");
        cyc(2'b11, 5'h0, 1, 0, 2'd1, 8'h0, "R3 rise ind");
        cyc(2'b11, 5'h0, 1, 0, 2'd1, 8'h0, "R3 rise mf ind");
        cyc(2'b11, 5'h0, 1, 0, 2'd1, 8'h0, "R6 cleared");
        // R4 falling edge
        cyc(2'b10, 5'h0, 0, 0, 2'd0, 8'h0, "");
        cyc(2'b10, 5'h0, 1, 0, 2'd1, 8'h0, "R4 fall ind");
        cyc(2'b00, 5'h0, 0, 0, 2'd0, 8'h0, "");
        cyc(2'b00, 5'h0, 1, 0, 2'd1, 8'h0, "R4 fall mf ind");
        // R5 each pulse on its own bit
        for (int k = 0; k < 5; k++) begin
            cyc(2'b00, 5'(1 << k), 0, 0, 2'd0, 8'h0, "");
            cyc(2'b00, 5'h0, 1, 0, 2'd1, 8'h0, "R5 pulse bit");
        end
        // R7 event during read
        cyc(2'b00, 5'h01, 0, 0, 2'd0, 8'h0, "");
        cyc(2'b00, 5'h10, 1, 0, 2'd1, 8'h0, "R7 read with event");
        cyc(2'b00, 5'h00, 1, 0, 2'd1, 8'h0, "R7 event kept");
        // R11 sticky through idle cycles
        cyc(2'b00, 5'h08, 0, 0, 2'd0, 8'h0, "");
        repeat (6) cyc(2'b00, 5'h0, 0, 0, 2'd0, 8'h0, "");
        cyc(2'b00, 5'h0, 1, 0, 2'd1, 8'h0, "R11 sticky");
        // R10 writes to read-only and unused addresses
        cyc(2'b00, 5'h02, 0, 0, 2'd0, 8'h0, "");
        cyc(2'b00, 5'h0, 1, 1, 2'd1, 8'hff, "");
        cyc(2'b00, 5'h0, 1, 1, 2'd0, 8'hff, "");
        cyc(2'b00, 5'h0, 1, 1, 2'd3, 8'hff, "");
        cyc(2'b00, 5'h0, 1, 0, 2'd0, 8'h0, "R10 status unchanged");
        cyc(2'b00, 5'h0, 1, 0, 2'd2, 8'h0, "R10 en unchanged");
        cyc(2'b00, 5'h0, 1, 0, 2'd1, 8'h0, "R10 ind unchanged");
        // R8 enable register, R9 irq follows
        cyc(2'b00, 5'h0, 1, 1, 2'd2, 8'hff, "");
        cyc(2'b00, 5'h0, 1, 0, 2'd2, 8'h0, "R8 en readback");
        cyc(2'b00, 5'h0, 1, 1, 2'd2, 8'h04, "");
        cyc(2'b00, 5'h02, 0, 0, 2'd0, 8'h0, "");
        cyc(2'b00, 5'h01, 0, 0, 2'd0, 8'h0, "R9 masked then enabled");
        cyc(2'b00, 5'h0, 1, 0, 2'd1, 8'h0, "R6 read");
        // random mix
        lv = 2'b00;
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] ev;
            logic [1:0] a;
            logic v, w;
            if ($urandom_range(0, 5) == 0) lv = 2'($urandom);
            ev = 5'($urandom) & 5'($urandom) & 5'($urandom);
            v  = ($urandom_range(0, 2) == 0);
            w  = ($urandom_range(0, 3) == 0);
            a  = 2'($urandom);
            cyc(lv, ev, v, w, a, 8'($urandom),
                (a == 2'd0) ? "R2 rnd" : (a == 2'd1) ? "R6 rnd" :
                (a == 2'd2) ? "R8 rnd" : "R10 rnd");
        end
        cyc(2'b00, 5'h0, 0, 0, 2'd0, 8'h0, "");
        @(negedge clk);
        chk("R9 irq", {7'b0, irq_o}, {7'b0, m_irq});
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule